// File: doc/BRIEF.md
# Address-Range Read/Write Access Filter

This block is a request firewall placed in front of an on-chip SRAM. It looks at each incoming request (address, direction and whether the initiator is trusted) and decides in the same cycle whether to pass it downstream. Requests from a trusted initiator always pass. Requests from an untrusted initiator must land inside a configured address region. That region must also grant the specific direction of the access.

Every region entry holds an inclusive base and limit, plus two separate permission bits: one for reads and one for writes. As a result, an area can be readable without being writable. When a request is refused, nothing is forwarded. The filter then raises an error response on the following cycle.

The region table has four entries and can be reprogrammed through a small configuration port. A trusted initiator's update takes effect from the next cycle. An untrusted attempt leaves the table untouched and is answered with a configuration error one cycle later.

Top module: `region_rw_filter`

## Requirements
- R1: A valid request with `req_trusted`=1 is always forwarded (`fwd_valid`=1, `deny`=0), whatever its address and direction.
- R2: After reset, entry 0 covers 0xA0000000 to 0xA000FFFF with both reads and writes allowed. Untrusted reads and writes there are forwarded.
- R3: After reset, entry 1 covers 0xA0010000 to 0xA001FFFF with reads allowed and writes refused. An untrusted read there is forwarded, and an untrusted write is denied.
- R4: An untrusted request whose address lies in no region is denied. After reset, entries 2 and 3 are empty (base 0xFFFFFFFF, limit 0) and match no address.
- R5: For a valid request, `fwd_valid` and `deny` are never both high. Either one is high only while `req_valid`=1. `resp_err` is high exactly in the cycle after a cycle with `deny`=1.
- R6: Region bounds are inclusive: both the base and the limit address match, while base-1 and limit+1 do not.
- R7: When several entries match, the lowest-numbered one decides. A permissive higher entry does not open an address that a lower entry refuses, and a restrictive higher entry does not close an address that a lower entry allows.
- R8: A configuration write (`cfg_we`=1) with `cfg_trusted`=1 loads entry `cfg_idx` with `cfg_base`, `cfg_limit`, `cfg_rd` (read enable) and `cfg_wr` (write enable). The new entry applies from the next cycle, and `cfg_err` stays 0.
- R9: A configuration write with `cfg_trusted`=0 leaves the table unchanged, and `cfg_err` is 1 in the following cycle.
- R10: Out of reset, `resp_err` and `cfg_err` are 0, and with no request pending neither `fwd_valid` nor `deny` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request target address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_trusted | input | 1 | Request comes from a trusted initiator |
| cfg_we | input | 1 | Region table update strobe |
| cfg_trusted | input | 1 | Table update comes from a trusted initiator |
| cfg_idx | input | IDX_W | Entry to update |
| cfg_base | input | ADDR_W | New inclusive lower bound |
| cfg_limit | input | ADDR_W | New inclusive upper bound |
| cfg_rd | input | 1 | New read-enable bit |
| cfg_wr | input | 1 | New write-enable bit |
| fwd_valid | output | 1 | Request forwarded to the SRAM |
| deny | output | 1 | Request refused this cycle |
| resp_err | output | 1 | Error response, one cycle after a refusal |
| cfg_err | output | 1 | Error response, one cycle after an untrusted table update |

## Verification
The embedded assertions check, on every cycle, the behaviours that do not depend on the table's contents. Forward and deny must be exclusive, and each must be tied to a valid request. Trusted requests must always pass. The error response must follow each refusal by exactly one cycle. An untrusted table update must leave every entry unchanged and raise the configuration error.

The region decisions themselves can only be shown by the bench's directed scenarios. These cover the reset map, the read-only behaviour of the second region, the inclusive edges, misses, overlap priority and the visible effect of trusted and untrusted reprogramming.

// File: rtl/region_rw_filter.sv
module region_rw_filter #(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 4,
  parameter int IDX_W  = $clog2(N_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_trusted,
  input  logic              cfg_we,
  input  logic              cfg_trusted,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  output logic              fwd_valid,
  output logic              deny,
  output logic              resp_err,
  output logic              cfg_err
);

  localparam logic [ADDR_W-1:0] R0_LO = ADDR_W'(32'hA000_0000);
  localparam logic [ADDR_W-1:0] R0_HI = ADDR_W'(32'hA000_FFFF);
  localparam logic [ADDR_W-1:0] R1_LO = ADDR_W'(32'hA001_0000);
  localparam logic [ADDR_W-1:0] R1_HI = ADDR_W'(32'hA001_FFFF);

  logic [N_REG-1:0][ADDR_W-1:0] base_q, limit_q;
  logic [N_REG-1:0]             rd_q, wr_q;
  logic                         perm;

  always_comb begin
    perm = 1'b0;
    for (int i = N_REG - 1; i >= 0; i--)
      if (req_addr >= base_q[i] && req_addr <= limit_q[i])
        perm = req_write ? wr_q[i] : rd_q[i];
  end

  assign fwd_valid = req_valid & (req_trusted | perm);
  assign deny      = req_valid & ~(req_trusted | perm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) begin
        base_q[i]  <= '1;
        limit_q[i] <= '0;
        rd_q[i]    <= 1'b0;
        wr_q[i]    <= 1'b0;
      end
      base_q[0] <= R0_LO; limit_q[0] <= R0_HI; rd_q[0] <= 1'b1; wr_q[0] <= 1'b1;
      base_q[1] <= R1_LO; limit_q[1] <= R1_HI; rd_q[1] <= 1'b1; wr_q[1] <= 1'b0;
      resp_err <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (cfg_we && cfg_trusted) begin
        base_q[cfg_idx]  <= cfg_base;
        limit_q[cfg_idx] <= cfg_limit;
        rd_q[cfg_idx]    <= cfg_rd;
        wr_q[cfg_idx]    <= cfg_wr;
      end
      resp_err <= deny;
      cfg_err  <= cfg_we & ~cfg_trusted;
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && deny));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!fwd_valid && !deny));
  p_trusted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_trusted) |-> fwd_valid);
  p_err_after_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> resp_err);
  p_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !deny |=> !resp_err);
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_trusted) |=> ($stable(base_q) && $stable(limit_q) && $stable(rd_q) && $stable(wr_q)));
  p_cfg_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_trusted) |=> cfg_err);
  p_cfg_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_trusted) |=> !cfg_err);

endmodule

// File: tb/sim_region_rw_filter.sv
module sim_region_rw_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_trusted = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0, cfg_trusted = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic        fwd_valid, deny, resp_err, cfg_err;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  region_rw_filter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_trusted(req_trusted), .cfg_we(cfg_we),
    .cfg_trusted(cfg_trusted), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .fwd_valid(fwd_valid), .deny(deny), .resp_err(resp_err), .cfg_err(cfg_err));

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_req(input string tag, input logic [31:0] a, input logic wr,
                        input logic tr, input logic exp_fwd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_trusted = tr;
    #1;
    check({tag, " fwd"}, fwd_valid, exp_fwd);
    check({tag, " deny"}, deny, !exp_fwd);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " resp_err"}, resp_err, !exp_fwd);
  endtask

  task automatic do_cfg(input string tag, input logic tr, input logic [1:0] idx,
                        input logic [31:0] lo, input logic [31:0] hi,
                        input logic rd, input logic wr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_trusted = tr; cfg_idx = idx;
    cfg_base = lo; cfg_limit = hi; cfg_rd = rd; cfg_wr = wr;
    @(negedge clk);
    cfg_we = 1'b0;
    check({tag, " cfg_err"}, cfg_err, !tr);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 resp_err", resp_err, 1'b0);
    check("R10 cfg_err", cfg_err, 1'b0);
    check("R10 idle fwd", fwd_valid, 1'b0);
    check("R10 idle deny", deny, 1'b0);
  endtask

  task automatic t_reset_map;
    do_req("R2 rd region0", 32'hA000_0100, 1'b0, 1'b0, 1'b1);
    do_req("R2 wr region0", 32'hA000_8000, 1'b1, 1'b0, 1'b1);
    do_req("R3 rd region1", 32'hA001_0010, 1'b0, 1'b0, 1'b1);
    do_req("R3 wr region1", 32'hA001_0010, 1'b1, 1'b0, 1'b0);
    do_req("R4 miss rd", 32'hB000_0010, 1'b0, 1'b0, 1'b0);
    do_req("R4 miss wr zero", 32'h0000_0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_edges;
    do_req("R6 base0 wr", 32'hA000_0000, 1'b1, 1'b0, 1'b1);
    do_req("R6 limit0 wr", 32'hA000_FFFF, 1'b1, 1'b0, 1'b1);
    do_req("R6 base1 wr", 32'hA001_0000, 1'b1, 1'b0, 1'b0);
    do_req("R6 limit1 rd", 32'hA001_FFFF, 1'b0, 1'b0, 1'b1);
    do_req("R6 above1 rd", 32'hA002_0000, 1'b0, 1'b0, 1'b0);
    do_req("R6 below0 rd", 32'h9FFF_FFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_trusted;
    do_req("R1 trusted wr region1", 32'hA001_0000, 1'b1, 1'b1, 1'b1);
    do_req("R1 trusted rd miss", 32'h0000_0040, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_cfg;
    do_cfg("R9 untrusted cfg", 1'b0, 2'd2, 32'hB000_0000, 32'hB000_00FF, 1'b1, 1'b1);
    do_req("R9 table unchanged", 32'hB000_0010, 1'b0, 1'b0, 1'b0);
    do_cfg("R8 trusted cfg", 1'b1, 2'd2, 32'hB000_0000, 32'hB000_00FF, 1'b1, 1'b1);
    do_req("R8 new rd", 32'hB000_0010, 1'b0, 1'b0, 1'b1);
    do_req("R8 new wr", 32'hB000_00FF, 1'b1, 1'b0, 1'b1);
    do_req("R8 past new limit", 32'hB000_0100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overlap;
    do_cfg("R7 permissive entry3", 1'b1, 2'd3, 32'hA001_0000, 32'hA001_0FFF, 1'b1, 1'b1);
    do_req("R7 entry1 still refuses wr", 32'hA001_0000, 1'b1, 1'b0, 1'b0);
    do_cfg("R7 restrictive entry2", 1'b1, 2'd2, 32'hA000_0000, 32'hA000_00FF, 1'b0, 1'b0);
    do_req("R7 entry0 still allows wr", 32'hA000_0080, 1'b1, 1'b0, 1'b1);
    do_req("R7 entry0 still allows rd", 32'hA000_0000, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_reset_map;
    t_edges;
    t_trusted;
    t_cfg;
    t_overlap;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule